// File: doc/BRIEF.md
# Debug command pacing sequencer

This block runs on the host end of a single-wire background debug link. It takes one debug command at a time (kind, address, write data) and hands its phases to a serial bit-transmitter through a start strobe, a phase code and a payload. After the transmitter reports each phase with a done pulse, the sequencer can hold off the next serial activity for a minimum number of target bus-clock cycles. Those cycles arrive as single-cycle pulses on a tick input.

Where the gap sits depends on the kind of command. A bus-access read pauses between its address and its data read-back, so the target has time to find a free bus cycle. A bus-access write pauses after its data. A firmware read pauses between its command and its data, and a firmware write pauses after its data. Single-step and resume commands pause after the command itself, because the target reuses its shifter while it returns to user code. One down-counter, loaded from parameters, times every gap.

The ready flag stays low from the moment a command is accepted until its last gap has run out. A command offered while ready is low waits at the input and is taken as soon as ready rises.

Top module: `dbg_pace_seq`

## Requirements
- R1: During and after reset, cmd_ready_o is 1 and tx_start_o is 0, and tx_start_o stays 0 whenever cmd_ready_o is 1.
- R2: A command is accepted in a cycle where cmd_valid_i and cmd_ready_o are both 1. In the next cycle cmd_ready_o is 0 and tx_start_o pulses with tx_phase_o = 0 (command phase) and a payload equal to the zero-extended cmd_kind_i.
- R3: Phase codes are 0 command, 1 address and 2 data. Phases go out in that order. No start pulse is issued while a previous phase still awaits tx_done_i. The address payload is the accepted address, and the data payload is the accepted write data for write kinds and 0 for read kinds.
- R4: Kind 0 (bus read) sends command, address and data. Exactly HW_GAP ticks separate the address done from the data start.
- R5: Kind 1 (bus write) sends command, address and data. HW_GAP ticks must follow the data done before cmd_ready_o returns.
- R6: Kind 2 (firmware read) sends command and data with no address phase. FW_GAP ticks separate them.
- R7: Kind 3 (firmware write) sends command and data. FW_GAP ticks must follow the data done before cmd_ready_o returns.
- R8: Kinds 4 (single step) and 5 (resume) send the command phase only. EXIT_GAP ticks must follow it before cmd_ready_o returns.
- R9: A tick in the same cycle as tx_done_i is not counted. With tick_i held at 1, the next start pulse or the rise of ready is seen G+2 cycles after the done cycle, where G is the gap.
- R10: A command offered while cmd_ready_o is 0 is held and accepted when ready rises. Kind, address and data are captured at acceptance, so later input changes do not affect the running command.
- R11: Kinds 6 and 7 send the command phase only, with no gap.
- R12: tx_start_o is a one-cycle pulse, exactly one per phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One pulse per target bus-clock cycle |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Sequencer idle, command can be taken |
| cmd_kind_i | input | 3 | Command kind code |
| cmd_addr_i | input | W | Target address |
| cmd_data_i | input | W | Write data |
| tx_start_o | output | 1 | Start one phase on the transmitter |
| tx_phase_o | output | 2 | Phase code of the current phase |
| tx_payload_o | output | W | Bits for the current phase |
| tx_done_i | input | 1 | Transmitter finished the phase |

## Verification
Two pairs of events can land in the same cycle. The first pair is a tick and the done pulse that loads the gap counter. The bench provokes this by holding the tick high for a firmware read. It then requires the data start to appear exactly gap-plus-two cycles after the done cycle, which shows the coincident tick was not counted and no later tick was lost. The second pair is a new command arriving in the same cycle as the last gap expiring. The bench keeps a firmware write offered during a resume command and scrambles the other inputs. It then checks that the held command starts right after ready rises, with the values captured at its own acceptance.

// File: rtl/dbg_pace_pkg.sv
package dbg_pace_pkg;
  localparam logic [2:0] K_HW_RD = 3'd0;
  localparam logic [2:0] K_HW_WR = 3'd1;
  localparam logic [2:0] K_FW_RD = 3'd2;
  localparam logic [2:0] K_FW_WR = 3'd3;
  localparam logic [2:0] K_STEP  = 3'd4;
  localparam logic [2:0] K_RESUME = 3'd5;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    GAP_NONE = 2'd0,
    GAP_HW   = 2'd1,
    GAP_FW   = 2'd2,
    GAP_EXIT = 2'd3
  } gap_sel_e;
endpackage

// File: rtl/dbg_pace_plan.sv
// Per-kind phase route: which gap follows the current phase and what comes next.
module dbg_pace_plan
  import dbg_pace_pkg::*;
(
  input  logic [2:0] kind_i,
  input  phase_e     phase_i,
  output gap_sel_e   gap_o,
  output logic       more_o,
  output phase_e     next_o
);
  always_comb begin
    gap_o  = GAP_NONE;
    more_o = 1'b0;
    next_o = PH_CMD;
    unique case (kind_i)
      K_HW_RD, K_HW_WR: begin
        unique case (phase_i)
          PH_CMD:  begin more_o = 1'b1; next_o = PH_ADDR; end
          PH_ADDR: begin
            more_o = 1'b1;
            next_o = PH_DATA;
            if (kind_i == K_HW_RD) gap_o = GAP_HW;
          end
          default: if (kind_i == K_HW_WR) gap_o = GAP_HW;
        endcase
      end
      K_FW_RD: begin
        if (phase_i == PH_CMD) begin
          gap_o  = GAP_FW;
          more_o = 1'b1;
          next_o = PH_DATA;
        end
      end
      K_FW_WR: begin
        if (phase_i == PH_CMD) begin
          more_o = 1'b1;
          next_o = PH_DATA;
        end else begin
          gap_o = GAP_FW;
        end
      end
      K_STEP, K_RESUME: gap_o = GAP_EXIT;
      default: ;
    endcase
  end
endmodule

// File: rtl/dbg_pace_gap_ctr.sv
// Shared gap timer: loads the selected length, counts target ticks down to zero.
module dbg_pace_gap_ctr
  import dbg_pace_pkg::*;
#(
  parameter int unsigned HW_GAP   = 150,
  parameter int unsigned FW_GAP   = 32,
  parameter int unsigned EXIT_GAP = 64
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  gap_sel_e sel_i,
  input  logic     tick_i,
  output logic     zero_o
);
  localparam int unsigned MAX_A = (HW_GAP > FW_GAP) ? HW_GAP : FW_GAP;
  localparam int unsigned MAX_G = (MAX_A > EXIT_GAP) ? MAX_A : EXIT_GAP;
  localparam int unsigned CW    = $clog2(MAX_G + 2);

  logic [CW-1:0] cnt_q, len;

  always_comb begin
    unique case (sel_i)
      GAP_HW:   len = CW'(HW_GAP);
      GAP_FW:   len = CW'(FW_GAP);
      GAP_EXIT: len = CW'(EXIT_GAP);
      default:  len = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= len;
    else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dbg_pace_seq.sv
module dbg_pace_seq
  import dbg_pace_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned HW_GAP   = 150,
  parameter int unsigned FW_GAP   = 32,
  parameter int unsigned EXIT_GAP = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         cmd_valid_i,
  output logic         cmd_ready_o,
  input  logic [2:0]   cmd_kind_i,
  input  logic [W-1:0] cmd_addr_i,
  input  logic [W-1:0] cmd_data_i,
  output logic         tx_start_o,
  output logic [1:0]   tx_phase_o,
  output logic [W-1:0] tx_payload_o,
  input  logic         tx_done_i
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_GAP} st_e;

  st_e          st_q, st_d;
  phase_e       ph_q, ph_d;
  logic [2:0]   kind_q;
  logic [W-1:0] addr_q, data_q;
  logic         take, load, zero, more;
  gap_sel_e     gap;
  phase_e       next_ph;

  dbg_pace_plan u_plan (
    .kind_i (kind_q),
    .phase_i(ph_q),
    .gap_o  (gap),
    .more_o (more),
    .next_o (next_ph)
  );

  dbg_pace_gap_ctr #(
    .HW_GAP  (HW_GAP),
    .FW_GAP  (FW_GAP),
    .EXIT_GAP(EXIT_GAP)
  ) u_gap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .sel_i (gap),
    .tick_i(tick_i),
    .zero_o(zero)
  );

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    take = 1'b0;
    load = 1'b0;
    unique case (st_q)
      ST_IDLE: if (cmd_valid_i) begin
        take = 1'b1;
        ph_d = PH_CMD;
        st_d = ST_ISSUE;
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: if (tx_done_i) begin
        if (gap != GAP_NONE) begin
          load = 1'b1;
          st_d = ST_GAP;
        end else if (more) begin
          ph_d = next_ph;
          st_d = ST_ISSUE;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: if (zero) begin
        if (more) begin
          ph_d = next_ph;
          st_d = ST_ISSUE;
        end else begin
          st_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_CMD;
      kind_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      if (take) begin
        kind_q <= cmd_kind_i;
        addr_q <= cmd_addr_i;
        data_q <= cmd_data_i;
      end
    end
  end

  logic is_write;
  assign is_write = (kind_q == K_HW_WR) || (kind_q == K_FW_WR);

  always_comb begin
    unique case (ph_q)
      PH_ADDR: tx_payload_o = addr_q;
      PH_DATA: tx_payload_o = is_write ? data_q : '0;
      default: tx_payload_o = W'(kind_q);
    endcase
  end

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign tx_start_o  = (st_q == ST_ISSUE);
  assign tx_phase_o  = ph_q;
endmodule

// File: rtl/dbg_pace_chk.sv
module dbg_pace_chk
  import dbg_pace_pkg::*;
#(
  parameter int unsigned HW_GAP   = 150,
  parameter int unsigned EXIT_GAP = 64
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       cmd_valid_i,
  input logic       cmd_ready_o,
  input logic [2:0] cmd_kind_i,
  input logic       tx_start_o,
  input logic [1:0] tx_phase_o,
  input logic       tx_done_i
);
  logic [2:0]  kind_q;
  logic [1:0]  last_ph_q;
  logic        pend_q;
  logic [31:0] ticks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q    <= '0;
      last_ph_q <= '0;
      pend_q    <= 1'b0;
      ticks_q   <= '0;
    end else begin
      if (cmd_valid_i && cmd_ready_o) kind_q <= cmd_kind_i;
      if (tx_start_o) last_ph_q <= tx_phase_o;
      if (tx_start_o)     pend_q <= 1'b1;
      else if (tx_done_i) pend_q <= 1'b0;
      if (tx_done_i)                    ticks_q <= '0;
      else if (tick_i && ticks_q != '1) ticks_q <= ticks_q + 32'd1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !tx_start_o);

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> !cmd_ready_o && tx_start_o && tx_phase_o == 2'd0);

  assert_phase_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o && tx_phase_o != 2'd0 |-> tx_phase_o > last_ph_q);

  assert_wait_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> !pend_q);

  assert_read_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o && tx_phase_o == 2'd2 && kind_q == K_HW_RD |-> ticks_q >= HW_GAP);

  assert_write_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_ready_o) && kind_q == K_HW_WR |-> ticks_q >= HW_GAP);

  assert_exit_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_ready_o) && (kind_q == K_STEP || kind_q == K_RESUME) |-> ticks_q >= EXIT_GAP);

  assert_single_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);
endmodule

bind dbg_pace_seq dbg_pace_chk #(
  .HW_GAP  (HW_GAP),
  .EXIT_GAP(EXIT_GAP)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .cmd_valid_i(cmd_valid_i),
  .cmd_ready_o(cmd_ready_o),
  .cmd_kind_i (cmd_kind_i),
  .tx_start_o (tx_start_o),
  .tx_phase_o (tx_phase_o),
  .tx_done_i  (tx_done_i)
);

// File: tb/tb_dbg_pace_seq.sv
module tb_dbg_pace_seq;
  localparam int HW_G = 150;
  localparam int FW_G = 32;
  localparam int EX_G = 64;

  typedef struct packed {
    logic [2:0]  kind;
    logic [15:0] addr;
    logic [15:0] data;
    logic [2:0]  nph;
    logic [5:0]  phases;  // phase j at [2*j +: 2]
    logic [23:0] gaps;    // ticks after phase j at [8*j +: 8]
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 16'h1234, 16'h5555, 3'd3, {2'd2, 2'd1, 2'd0}, {8'd0, 8'(HW_G), 8'd0}},
    '{3'd1, 16'h0F00, 16'hA5C3, 3'd3, {2'd2, 2'd1, 2'd0}, {8'(HW_G), 16'd0}},
    '{3'd2, 16'h7777, 16'h1111, 3'd2, {2'd0, 2'd2, 2'd0}, {16'd0, 8'(FW_G)}},
    '{3'd3, 16'h2222, 16'hBEEF, 3'd2, {2'd0, 2'd2, 2'd0}, {8'd0, 8'(FW_G), 8'd0}},
    '{3'd4, 16'h3333, 16'h4444, 3'd1, 6'd0, {16'd0, 8'(EX_G)}},
    '{3'd5, 16'h9999, 16'h8888, 3'd1, 6'd0, {16'd0, 8'(EX_G)}},
    '{3'd6, 16'hABCD, 16'hDCBA, 3'd1, 6'd0, 24'd0},
    '{3'd7, 16'hFFFF, 16'h0001, 3'd1, 6'd0, 24'd0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic [2:0]  kind = '0;
  logic [15:0] addr = '0;
  logic [15:0] data = '0;
  logic        start;
  logic [1:0]  phase;
  logic [15:0] payload;
  logic        done = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  int          got_n;
  logic [1:0]  got_ph [4];
  logic [15:0] got_pl [4];
  int          got_gap [4];
  int          got_cyc [4];

  always #10 clk = ~clk;

  dbg_pace_seq #(.W(16), .HW_GAP(HW_G), .FW_GAP(FW_G), .EXIT_GAP(EX_G)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .cmd_valid_i(valid), .cmd_ready_o(ready), .cmd_kind_i(kind),
    .cmd_addr_i(addr), .cmd_data_i(data),
    .tx_start_o(start), .tx_phase_o(phase), .tx_payload_o(payload),
    .tx_done_i(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_pl(input logic [2:0] k, input logic [1:0] ph,
                                         input logic [15:0] a, input logic [15:0] d);
    if (ph == 2'd0) return {13'd0, k};
    if (ph == 2'd1) return a;
    return (k == 3'd1 || k == 3'd3) ? d : 16'd0;
  endfunction

  function automatic string gap_tag(input logic [2:0] k);
    case (k)
      3'd0: return "R4 bus read gap";
      3'd1: return "R5 bus write gap";
      3'd2: return "R6 firmware read gap";
      3'd3: return "R7 firmware write gap";
      3'd4, 3'd5: return "R8 exit gap";
      default: return "R11 reserved kind gap";
    endcase
  endfunction

  // Offers a command (or collects an already-held one), answers each phase with done
  // two cycles after its start, and counts ticks between each done and the next event.
  task automatic run_cmd(input logic [2:0] k, input logic [15:0] a, input logic [15:0] d,
                         input bit offer, input bit hold,
                         input logic [2:0] nk, input logic [15:0] na, input logic [15:0] nd,
                         input bit ctick);
    int dcnt = 0;
    int tc = 0;
    int done_at = 0;
    int guard = 0;
    bit counting = 1'b0;
    bit fin = 1'b0;
    got_n = 0;
    for (int i = 0; i < 4; i++) begin
      got_ph[i] = '0; got_pl[i] = '0; got_gap[i] = -1; got_cyc[i] = -1;
    end
    if (offer) begin
      @(negedge clk);
      valid = 1'b1; kind = k; addr = a; data = d;
    end
    while (!fin) begin
      @(negedge clk);
      cyc++;
      guard++;
      if (guard == 1) begin
        if (hold) begin
          valid = 1'b1; kind = nk; addr = na; data = nd;
        end else begin
          valid = 1'b0; addr = ~addr; data = ~data; kind = ~kind;
        end
      end
      done = 1'b0;
      if (start) begin
        if (counting && got_n > 0 && got_n <= 4) begin
          got_gap[got_n-1] = tc; got_cyc[got_n-1] = cyc - done_at;
        end
        counting = 1'b0;
        if (got_n < 4) begin
          got_ph[got_n] = phase; got_pl[got_n] = payload;
        end
        got_n++;
        dcnt = 2;
      end else if (ready) begin
        if (got_n > 0 && got_n <= 4) begin
          got_gap[got_n-1] = tc; got_cyc[got_n-1] = cyc - done_at;
        end
        counting = 1'b0;
        fin = 1'b1;
      end else if (dcnt > 0) begin
        dcnt--;
        if (dcnt == 0) begin
          done = 1'b1; counting = 1'b1; tc = 0; done_at = cyc;
        end
      end
      tick = ctick ? 1'b1 : (cyc % 3 == 0);
      if (counting && !done && tick) tc++;
      if (guard > 5000) begin
        chk(1'b0, "R3 command never completed", guard, 0);
        fin = 1'b1;
      end
    end
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1 ready in reset", int'(ready), 1);
    chk(start == 1'b0, "R1 no start in reset", int'(start), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
    chk(start == 1'b0, "R1 no start after reset", int'(start), 0);

    foreach (VECS[i]) begin
      vec_t v;
      v = VECS[i];
      run_cmd(v.kind, v.addr, v.data, 1'b1, 1'b0, 3'd0, 16'd0, 16'd0, 1'b0);
      chk(got_n == int'(v.nph), "R12 one start per phase", got_n, int'(v.nph));
      for (int j = 0; j < int'(v.nph) && j < 4; j++) begin
        chk(got_ph[j] == v.phases[2*j +: 2], "R3 phase order",
            int'(got_ph[j]), int'(v.phases[2*j +: 2]));
        chk(got_pl[j] == exp_pl(v.kind, got_ph[j], v.addr, v.data),
            (j == 0) ? "R2 command payload" : "R10 captured payload",
            int'(got_pl[j]), int'(exp_pl(v.kind, got_ph[j], v.addr, v.data)));
        chk(got_gap[j] == int'(v.gaps[8*j +: 8]), gap_tag(v.kind),
            got_gap[j], int'(v.gaps[8*j +: 8]));
      end
    end

    // R9: tick held high, tick coincident with done must not count
    run_cmd(3'd2, 16'h0, 16'h0, 1'b1, 1'b0, 3'd0, 16'd0, 16'd0, 1'b1);
    chk(got_n == 2, "R9 phase count", got_n, 2);
    chk(got_cyc[0] == FW_G + 2, "R9 continuous tick spacing", got_cyc[0], FW_G + 2);
    chk(got_ph[1] == 2'd2, "R9 data follows gap", int'(got_ph[1]), 2);

    // R10: firmware write offered while a resume runs, other inputs scrambled on acceptance
    run_cmd(3'd5, 16'h0, 16'h0, 1'b1, 1'b1, 3'd3, 16'h4242, 16'hCAFE, 1'b0);
    chk(got_n == 1, "R10 held command not started early", got_n, 1);
    chk(got_pl[0] == 16'd5, "R10 first command intact", int'(got_pl[0]), 5);
    chk(got_gap[0] == EX_G, "R8 resume gap before held command", got_gap[0], EX_G);
    run_cmd(3'd0, 16'h0, 16'h0, 1'b0, 1'b0, 3'd0, 16'd0, 16'd0, 1'b0);
    chk(got_n == 2, "R10 held command phases", got_n, 2);
    chk(got_ph[0] == 2'd0 && got_pl[0] == 16'd3, "R10 held command kind",
        int'(got_pl[0]), 3);
    chk(got_ph[1] == 2'd2 && got_pl[1] == 16'hCAFE, "R10 held command data",
        int'(got_pl[1]), 16'hCAFE);
    chk(got_gap[1] == FW_G, "R7 held write gap", got_gap[1], FW_G);

    @(negedge clk);
    chk(ready == 1'b1 && start == 1'b0, "R1 idle at end", int'(ready), 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule